// File: doc/BRIEF.md
# Ping-Pong Conversion Result Transfer Controller

This block stores every new result from a data converter in a memory buffer with no processor involvement. Each result-valid strobe becomes one word write at the current buffer address. The buffer is either a single block of N words or two adjacent blocks of N words that are filled in turn. Software sets a start address and a block size, picks single or dual-block operation, and chooses whether the run stops after one pass or repeats. A block-complete flag is raised whenever a block fills. In dual-block mode a status bit shows which half just filled, so software can drain one half while the other fills.

Software reaches the block through a register port. Writes take effect on the clock edge and reads are combinational. There are four registers, picked by `reg_sel`:
- Control, select 0.
- Start address, select 1.
- Block size, select 2.
- Flag, select 3.

Writing the start address restarts the run from the first word of the first block. Clearing the continuous bit halts a repeating run at once.

Top module: `pp_xfer_ctrl`

## Requirements
- R1: Control register (select 0) layout: bit 3 enables dual-block mode, bit 2 enables continuous mode, bit 1 is a read-only status bit, and bit 0 is a spare bit that is stored and read back with no effect on transfers. All bits above bit 3 read as zero. Writing 0xFF just after reset reads back 0x0D.
- R2: While the controller is armed and the block size is not zero, each `res_valid` cycle drives `mem_we` high in that same cycle. `mem_wdata` equals `res_data`, and the next write goes to the following word address.
- R3: In single-block mode, the writes cover start .. start+N-1. With continuous mode off, later strobes produce no write.
- R4: In dual-block mode, the second block covers start+N .. start+2N-1 right after the first. With continuous mode off, the controller stops after 2N writes.
- R5: With continuous mode on, the address returns to the start address after the last block, and this repeats indefinitely. A control write that clears the continuous bit stops transfers at once, so the next strobe produces no write.
- R6: The flag (`irq_flag`, also flag register bit 0) rises in the cycle after the last word of each block is written. In dual-block mode the status bit then reads 1 if the first block filled and 0 if the second block filled.
- R7: Writing 1 to bit 0 of the flag register (select 3) clears the flag. Writing 0 leaves it unchanged. If a clear and a block completion fall in the same cycle, the flag ends up set.
- R8: A block size of zero blocks all writes.
- R9: Writing the start address (select 1) sets the next write to that address in the first block and arms the controller, even in the middle of a run.
- R10: After reset, all registers read zero, the flag is low and strobes produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 start, 2 size, 3 flag |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| res_valid | input | 1 | New conversion result present |
| res_data | input | DW | Conversion result |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| irq_flag | output | 1 | Block-complete flag |

## Verification
The memory write port is combinational from the strobe, so `mem_we`, `mem_addr` and `mem_wdata` are sampled 1 ns after the strobe is driven, while the strobe cycle is still open. The flag and the status bit are registered. They are sampled 1 ns after the rising edge that takes the final word of a block. A register write lands on the edge that closes its cycle, so its effect is checked on the next strobe. The bench covers every combination of the two mode bits with block sizes 1 and 3, and computes each expected address as start plus the write count modulo the run length.

// File: rtl/pp_xfer_pkg.sv
package pp_xfer_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_START = 2'd1,
    SEL_SIZE  = 2'd2,
    SEL_FLAG  = 2'd3
  } reg_sel_e;

  localparam int CTRL_DUAL_BIT  = 3;
  localparam int CTRL_CONT_BIT  = 2;
  localparam int CTRL_STAT_BIT  = 1;
  localparam int CTRL_SPARE_BIT = 0;
  localparam int CTRL_FIELD_W   = 4;
endpackage

// File: rtl/pp_rst_sync.sv
module pp_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/pp_cfg_regs.sv
module pp_cfg_regs
  import pp_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  input  logic          stat_bit,
  input  logic          flag,
  output logic          dual_blk,
  output logic          cont,
  output logic [AW-1:0] start_addr,
  output logic [CW-1:0] blk_size,
  output logic          start_wr,
  output logic          cont_fall,
  output logic          flag_clr,
  output logic [AW-1:0] reg_rdata
);
  localparam int PAD_CTRL = AW - CTRL_FIELD_W;
  localparam int PAD_SIZE = AW - CW;

  logic          dual_q, dual_d;
  logic          cont_q, cont_d;
  logic          spare_q, spare_d;
  logic [AW-1:0] start_q, start_d;
  logic [CW-1:0] size_q, size_d;
  reg_sel_e      sel;

  assign sel = reg_sel_e'(reg_sel);

  always_comb begin
    dual_d  = dual_q;
    cont_d  = cont_q;
    spare_d = spare_q;
    start_d = start_q;
    size_d  = size_q;
    if (reg_we) begin
      case (sel)
        SEL_CTRL: begin
          dual_d  = reg_wdata[CTRL_DUAL_BIT];
          cont_d  = reg_wdata[CTRL_CONT_BIT];
          spare_d = reg_wdata[CTRL_SPARE_BIT];
        end
        SEL_START: start_d = reg_wdata;
        SEL_SIZE:  size_d  = reg_wdata[CW-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dual_q  <= 1'b0;
      cont_q  <= 1'b0;
      spare_q <= 1'b0;
      start_q <= '0;
      size_q  <= '0;
    end else if (reg_we) begin
      dual_q  <= dual_d;
      cont_q  <= cont_d;
      spare_q <= spare_d;
      start_q <= start_d;
      size_q  <= size_d;
    end
  end

  assign start_wr  = reg_we && (sel == SEL_START);
  assign cont_fall = reg_we && (sel == SEL_CTRL) && cont_q && !reg_wdata[CTRL_CONT_BIT];
  assign flag_clr  = reg_we && (sel == SEL_FLAG) && reg_wdata[0];

  always_comb begin
    case (sel)
      SEL_CTRL:  reg_rdata = {{PAD_CTRL{1'b0}}, dual_q, cont_q, stat_bit, spare_q};
      SEL_START: reg_rdata = start_q;
      SEL_SIZE:  reg_rdata = {{PAD_SIZE{1'b0}}, size_q};
      default:   reg_rdata = {{(AW-1){1'b0}}, flag};
    endcase
  end

  assign dual_blk   = dual_q;
  assign cont       = cont_q;
  assign start_addr = start_q;
  assign blk_size   = size_q;
endmodule

// File: rtl/pp_addr_gen.sv
module pp_addr_gen #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic          dual_blk,
  input  logic          cont,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] blk_size,
  input  logic          start_wr,
  input  logic          cont_fall,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          blk_done,
  output logic          stat_bit
);
  logic          armed_q, armed_d;
  logic          blk_q, blk_d;
  logic [CW-1:0] wcnt_q, wcnt_d;
  logic          stat_q, stat_d;
  logic          active, last_word, last_blk, upd_en;

  assign active    = armed_q && (blk_size != '0);
  assign mem_we    = res_valid && active;
  assign last_word = (wcnt_q == blk_size - CW'(1));
  assign last_blk  = !dual_blk || blk_q;
  assign blk_done  = mem_we && last_word;
  assign mem_addr  = start_addr + (blk_q ? AW'(blk_size) : AW'(0)) + AW'(wcnt_q);
  assign upd_en    = start_wr || cont_fall || mem_we;

  always_comb begin
    armed_d = armed_q;
    blk_d   = blk_q;
    wcnt_d  = wcnt_q;
    stat_d  = stat_q;
    if (start_wr) begin
      armed_d = 1'b1;
      blk_d   = 1'b0;
      wcnt_d  = '0;
    end else if (cont_fall) begin
      armed_d = 1'b0;
    end else if (mem_we) begin
      if (last_word) begin
        wcnt_d = '0;
        stat_d = !blk_q;
        if (last_blk) begin
          blk_d = 1'b0;
          if (!cont) armed_d = 1'b0;
        end else begin
          blk_d = 1'b1;
        end
      end else begin
        wcnt_d = wcnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      blk_q   <= 1'b0;
      wcnt_q  <= '0;
      stat_q  <= 1'b0;
    end else if (upd_en) begin
      armed_q <= armed_d;
      blk_q   <= blk_d;
      wcnt_q  <= wcnt_d;
      stat_q  <= stat_d;
    end
  end

  assign stat_bit = stat_q;

  // R2: consecutive writes within a block step by one word
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !last_word && !start_wr && !cont_fall)
      |=> (!$stable(blk_size) || mem_addr == $past(mem_addr) + AW'(1)));

  // R3/R4: a non-continuous run ends after its last block
  a_r3_stop_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && last_blk && !cont && !start_wr) |=> !mem_we);

  // R5: a continuous run wraps to the start address
  a_r5_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && last_blk && cont && !start_wr && !cont_fall)
      |=> (mem_addr == start_addr));

  // R9: a start-address write restarts at that address
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (mem_addr == start_addr));
endmodule

// File: rtl/pp_irq_flag.sv
module pp_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_done,
  input  logic flag_clr,
  output logic irq_flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (blk_done)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq_flag = flag_q;

  // R6: each block completion raises the flag
  a_r6_flag_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> irq_flag);

  // R7: a clear with no competing completion drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !blk_done) |=> !irq_flag);
endmodule

// File: rtl/pp_xfer_ctrl.sv
module pp_xfer_ctrl #(
  parameter int AW = 16,
  parameter int DW = 10,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          irq_flag
);
  logic          rst_n_s;
  logic          dual_blk, cont, start_wr, cont_fall, flag_clr;
  logic          blk_done, stat_bit;
  logic [AW-1:0] start_addr;
  logic [CW-1:0] blk_size;

  pp_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n       (rst_n_s)
  );

  pp_cfg_regs #(.AW(AW), .CW(CW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .stat_bit   (stat_bit),
    .flag       (irq_flag),
    .dual_blk   (dual_blk),
    .cont       (cont),
    .start_addr (start_addr),
    .blk_size   (blk_size),
    .start_wr   (start_wr),
    .cont_fall  (cont_fall),
    .flag_clr   (flag_clr),
    .reg_rdata  (reg_rdata)
  );

  pp_addr_gen #(.AW(AW), .CW(CW)) u_agen (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .res_valid  (res_valid),
    .dual_blk   (dual_blk),
    .cont       (cont),
    .start_addr (start_addr),
    .blk_size   (blk_size),
    .start_wr   (start_wr),
    .cont_fall  (cont_fall),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .blk_done   (blk_done),
    .stat_bit   (stat_bit)
  );

  pp_irq_flag u_irq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .blk_done (blk_done),
    .flag_clr (flag_clr),
    .irq_flag (irq_flag)
  );

  assign mem_wdata = res_data;

  // R8: a zero block size never lets a word through
  always_comb begin
    if (rst_n_s && blk_size == '0) a_r8_zero_size: assert (!mem_we);
  end
endmodule

// File: tb/pp_xfer_ctrl_tb.sv
module pp_xfer_ctrl_tb;
  localparam int AW = 16;
  localparam int DW = 10;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          res_valid = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          irq_flag;

  int vecs = 0;
  int errs = 0;

  always #2 clk = ~clk;

  pp_xfer_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .res_valid(res_valid),
    .res_data(res_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq_flag(irq_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int sel, input int data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = AW'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int sel, input int exp, input string req);
    reg_sel = 2'(sel);
    #1;
    chk(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
  endtask

  // drive one strobe and check the combinational write port
  task automatic pulse(input bit exp_we, input int exp_addr, input int data, input string req);
    @(negedge clk);
    res_valid = 1'b1; res_data = DW'(data);
    #1;
    chk(mem_we == exp_we, {req, " we"}, int'(mem_we), int'(exp_we));
    if (exp_we) begin
      chk(int'(mem_addr) == exp_addr, {req, " addr"}, int'(mem_addr), exp_addr);
      chk(int'(mem_wdata) == (data & 10'h3ff), "R2 data", int'(mem_wdata), data & 10'h3ff);
    end
    @(posedge clk); #1;
    res_valid = 1'b0;
  endtask

  task automatic run_combo(input bit dual, input bit cont, input int n, input int base);
    int rl;
    int total;
    string rq;
    rl = dual ? 2 * n : n;
    total = cont ? 2 * rl + n : rl + 2;
    rq = cont ? "R5" : (dual ? "R4" : "R3");
    wr_reg(2, n);
    wr_reg(0, (int'(dual) << 3) | (int'(cont) << 2));
    wr_reg(3, 1);
    wr_reg(1, base);
    for (int k = 0; k < total; k++) begin
      bit ew;
      int pos;
      ew = cont || (k < rl);
      pos = k % rl;
      pulse(ew, base + pos, k * 7 + n, rq);
      if (ew && (pos % n == n - 1)) begin
        chk(irq_flag == 1'b1, "R6 flag set", int'(irq_flag), 1);
        if (dual) rd_chk(0, 32'h0c & ((int'(dual) << 3) | (int'(cont) << 2))
                            | ((pos / n == 0) ? 2 : 0), "R6 status");
        wr_reg(3, 1);
        #1;
        chk(irq_flag == 1'b0, "R7 clear", int'(irq_flag), 0);
      end else begin
        chk(irq_flag == 1'b0, "R6 no early flag", int'(irq_flag), 0);
      end
    end
    if (cont) begin
      wr_reg(0, int'(dual) << 3);
      pulse(1'b0, 0, 5, "R5 cont cleared");
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_up();
  end

  initial begin
    #7 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    rd_chk(0, 0, "R10 ctrl");
    rd_chk(1, 0, "R10 start");
    rd_chk(2, 0, "R10 size");
    rd_chk(3, 0, "R10 flag");
    chk(irq_flag == 1'b0, "R10 irq", int'(irq_flag), 0);
    pulse(1'b0, 0, 1, "R10 idle");
    // R1: control layout
    wr_reg(0, 16'h00ff);
    rd_chk(0, 16'h000d, "R1 layout");
    wr_reg(0, 0);
    // R8: zero size blocks writes
    wr_reg(2, 0);
    wr_reg(1, 16'h0040);
    pulse(1'b0, 0, 2, "R8 zero size");
    pulse(1'b0, 0, 3, "R8 zero size");
    // sweep every mode combination
    for (int c = 0; c < 8; c++) begin
      run_combo(c[0], c[1], c[2] ? 3 : 1, 16'h0100 + c * 16'h0040);
    end
    // R1: spare bit stored without altering transfers
    wr_reg(2, 2);
    wr_reg(0, 1);
    wr_reg(1, 16'h0500);
    pulse(1'b1, 16'h0500, 9, "R1 spare");
    pulse(1'b1, 16'h0501, 9, "R1 spare");
    pulse(1'b0, 0, 9, "R1 spare stop");
    wr_reg(3, 1);
    // R9: restart in mid-run
    wr_reg(2, 4);
    wr_reg(0, 0);
    wr_reg(1, 16'h0600);
    pulse(1'b1, 16'h0600, 1, "R9");
    pulse(1'b1, 16'h0601, 2, "R9");
    wr_reg(1, 16'h0700);
    pulse(1'b1, 16'h0700, 3, "R9 restart");
    pulse(1'b1, 16'h0701, 4, "R9 restart");
    // R7: writing 0 keeps the flag; completion beats a clear
    wr_reg(2, 1);
    wr_reg(0, 16'h0004);
    wr_reg(1, 16'h0800);
    pulse(1'b1, 16'h0800, 5, "R7");
    chk(irq_flag == 1'b1, "R7 set", int'(irq_flag), 1);
    wr_reg(3, 0);
    chk(irq_flag == 1'b1, "R7 write zero", int'(irq_flag), 1);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = AW'(1);
    res_valid = 1'b1; res_data = DW'(6);
    #1;
    chk(mem_we == 1'b1, "R7 collide we", int'(mem_we), 1);
    @(posedge clk); #1;
    reg_we = 1'b0; res_valid = 1'b0;
    chk(irq_flag == 1'b1, "R7 completion wins", int'(irq_flag), 1);
    wr_reg(3, 1);
    chk(irq_flag == 1'b0, "R7 clear after", int'(irq_flag), 0);
    finish_up();
  end
endmodule